// File: doc/BRIEF.md
# DMA Bus Burst Planner

This block turns one DMA buffer transfer into a series of burst commands for a bus master. A transfer is described by a start byte address, a length in 32-bit words and a direction, receive or transmit. The bus-mode settings are also sampled when the transfer starts. After a start handshake the planner offers one command at a time: a start address, an HBURST code and a beat count. It waits for the consumer to accept each command before it computes the next one. Moving the data itself is left to other logic.

Burst size and type are not fixed. They depend on several mode settings together: fixed-type bursts, mixed bursts, address-aligned beats, a four-times length multiplier, and a choice between one shared length field and a separate field for receive. Two limits also apply. A burst never crosses a 1 KB address boundary. A burst never runs past the words that remain.

The control is a two-state machine. IDLE waits for a start. It takes the transition START when the length is non-zero, and the transition EMPTY when the length is zero, which returns to IDLE. ISSUE presents the current command. It takes NEXT when a command is accepted and words remain, and LAST when the accepted command uses up the remaining words, which returns to IDLE.

Top module: `dma_burst_planner`

## Requirements
- R1: `start_ready` is high only in IDLE. A start with `total_words` = 0 yields no command and leaves the block ready on the next cycle. After the last command is accepted, the block is ready again.
- R2: The first command address equals `start_addr`. Each later address is the previous address plus 4 × beats. The beats of all commands add up to `total_words`.
- R3: The effective maximum burst length is the selected field value, or 1 if that field is 0. No command has more beats than this maximum or fewer than one.
- R4: With `cfg_fixed` = 1, only SINGLE (3'b000, 1 beat), INCR4 (3'b011), INCR8 (3'b101) and INCR16 (3'b111) are used. Each command uses the largest of these that fits the remaining words, the maximum length and the boundary limit.
- R5: With `cfg_fixed` = 0 and `cfg_mixed` = 0, a command of one beat uses SINGLE. Any longer command uses INCR (3'b001), with beats equal to the smallest of the remaining words, the maximum length and the boundary limit.
- R6: With `cfg_fixed` = 0 and `cfg_mixed` = 1, a burst limit above 16 gives INCR with that many beats. A limit of 16 or less gives the fixed-type choice of R4.
- R7: With `cfg_aligned` = 1 and `cfg_fixed` = 1, every command address, including the first, is a multiple of 4 × beats bytes.
- R8: With `cfg_aligned` = 1 and `cfg_fixed` = 0, bursts are cut at multiples of the maximum length in words. The first burst may start unaligned, and every later burst starts aligned.
- R9: No command crosses a 1024-byte address boundary. A burst that would cross one is cut at the boundary.
- R10: While `cmd_valid` is high and `cmd_ready` is low, the command outputs hold their values into the next cycle.
- R11: With `cfg_x4` = 1, the maximum length is four times the selected field value.
- R12: With `cfg_sep_rx` = 1 and `dir_rx` = 1, the receive field `cfg_rx_pbl` is used. In every other case `cfg_pbl` is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Request to start a transfer |
| start_ready | output | 1 | Block is idle and can accept a start |
| start_addr | input | 32 | Buffer start byte address, word aligned |
| total_words | input | 16 | Transfer length in 32-bit words |
| dir_rx | input | 1 | 1 = receive transfer, 0 = transmit transfer |
| cfg_fixed | input | 1 | Use fixed-type bursts only |
| cfg_mixed | input | 1 | INCR above 16 beats, fixed types at or below 16 |
| cfg_aligned | input | 1 | Address-aligned beats |
| cfg_x4 | input | 1 | Multiply the burst-length field by four |
| cfg_sep_rx | input | 1 | Use the receive field for receive transfers |
| cfg_pbl | input | 6 | Main burst-length field (1, 2, 4, 8, 16 or 32) |
| cfg_rx_pbl | input | 6 | Receive burst-length field |
| cmd_valid | output | 1 | A burst command is presented |
| cmd_ready | input | 1 | The consumer accepts the command |
| cmd_addr | output | 32 | Burst start byte address |
| cmd_burst | output | 3 | HBURST code |
| cmd_beats | output | 8 | Beats in this burst |

## Verification
The case that is hardest to reach is a run with alignment, where the sizes change from burst to burst. Here an unaligned start forces single beats until the word index reaches a 4-word boundary. The sizes then grow through INCR4 and INCR8 and shrink again at the tail. The stimulus gets there by starting a transfer in fixed, aligned mode one word past a 16-word boundary, with a length chosen to walk through every size. A second start, placed four words below a 1 KB boundary, exposes the boundary cut. In this start the limit from the boundary is smaller than both the remaining words and the maximum length.

// File: rtl/bp_pkg.sv
package bp_pkg;
    localparam logic [2:0] HB_SINGLE = 3'b000;
    localparam logic [2:0] HB_INCR   = 3'b001;
    localparam logic [2:0] HB_INCR4  = 3'b011;
    localparam logic [2:0] HB_INCR8  = 3'b101;
    localparam logic [2:0] HB_INCR16 = 3'b111;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } plan_state_t;
endpackage

// File: rtl/bp_piece.sv
// Picks the largest fixed-type burst (16/8/4/1) that fits the limit and,
// when alignment is demanded, starts on a multiple of its own size.
module bp_piece
    import bp_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0] lim,
    input  logic [3:0]       widx_lo,
    input  logic             need_al,
    output logic [4:0]       piece_beats,
    output logic [2:0]       piece_code
);
    logic fit16, fit8, fit4;

    always_comb begin
        fit16 = (lim >= LEN_W'(16)) && (!need_al || widx_lo[3:0] == 4'd0);
        fit8  = (lim >= LEN_W'(8))  && (!need_al || widx_lo[2:0] == 3'd0);
        fit4  = (lim >= LEN_W'(4))  && (!need_al || widx_lo[1:0] == 2'd0);
        if (fit16) begin
            piece_beats = 5'd16;
            piece_code  = HB_INCR16;
        end else if (fit8) begin
            piece_beats = 5'd8;
            piece_code  = HB_INCR8;
        end else if (fit4) begin
            piece_beats = 5'd4;
            piece_code  = HB_INCR4;
        end else begin
            piece_beats = 5'd1;
            piece_code  = HB_SINGLE;
        end
    end
endmodule

// File: rtl/bp_sizer.sv
// Sizes the next burst from the current word index, remaining count and modes.
module bp_sizer
    import bp_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int BEAT_W = 8,
    parameter int BND_LG = 8,
    parameter int IDX_W  = 8
) (
    input  logic [IDX_W-1:0]  widx,
    input  logic [LEN_W-1:0]  rem,
    input  logic [BEAT_W-1:0] max_len,
    input  logic              fixed,
    input  logic              mixed,
    input  logic              aligned,
    input  logic              first,
    output logic [BEAT_W-1:0] beats,
    output logic [2:0]        burst
);
    localparam int BND_WORDS = 1 << BND_LG;

    logic [LEN_W-1:0] max_w, to_bnd, to_blk, lim_a, lim_b, lim;
    logic [BEAT_W-1:0] blk_off;
    logic             need_al;
    logic [4:0]       p_beats;
    logic [2:0]       p_code;

    always_comb begin
        max_w   = LEN_W'(max_len);
        to_bnd  = LEN_W'(BND_WORDS) - LEN_W'(widx[BND_LG-1:0]);
        blk_off = widx[BEAT_W-1:0] & (max_len - 1'b1);
        to_blk  = max_w - LEN_W'(blk_off);
        lim_a   = (rem < max_w) ? rem : max_w;
        lim_b   = (lim_a < to_bnd) ? lim_a : to_bnd;
        // Non-fixed aligned mode: end each burst on a max-length multiple
        if (aligned && !fixed && to_blk < lim_b) lim = to_blk;
        else                                     lim = lim_b;
        need_al = aligned && (fixed || !first);
    end

    bp_piece #(.LEN_W(LEN_W)) u_piece (
        .lim        (lim),
        .widx_lo    (widx[3:0]),
        .need_al    (need_al),
        .piece_beats(p_beats),
        .piece_code (p_code)
    );

    always_comb begin
        if (fixed || (mixed && lim <= LEN_W'(16))) begin
            beats = BEAT_W'(p_beats);
            burst = p_code;
        end else begin
            beats = lim[BEAT_W-1:0];
            burst = (lim == LEN_W'(1)) ? HB_SINGLE : HB_INCR;
        end
    end
endmodule

// File: rtl/dma_burst_planner.sv
module dma_burst_planner
    import bp_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 16,
    parameter int PBL_W    = 6,
    parameter int BEAT_W   = 8,
    parameter int BND_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  total_words,
    input  logic              dir_rx,
    input  logic              cfg_fixed,
    input  logic              cfg_mixed,
    input  logic              cfg_aligned,
    input  logic              cfg_x4,
    input  logic              cfg_sep_rx,
    input  logic [PBL_W-1:0]  cfg_pbl,
    input  logic [PBL_W-1:0]  cfg_rx_pbl,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [2:0]        cmd_burst,
    output logic [BEAT_W-1:0] cmd_beats
);
    localparam int BND_LG = $clog2(BND_BYTES / 4);
    localparam int IDX_W  = (BND_LG > BEAT_W) ? BND_LG : BEAT_W;

    plan_state_t state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic              first_q, fixed_q, mixed_q, aligned_q;
    logic [BEAT_W-1:0] max_q;
    logic [PBL_W-1:0]  sel_pbl;
    logic [BEAT_W-1:0] sel_eff;
    logic [BEAT_W-1:0] nx_beats;
    logic [2:0]        nx_burst;
    logic              take_start, take_cmd, last_cmd;

    // Selected and scaled maximum length, fixed at start time
    always_comb begin
        sel_pbl = (cfg_sep_rx && dir_rx) ? cfg_rx_pbl : cfg_pbl;
        if (sel_pbl == '0) sel_pbl = PBL_W'(1);
        sel_eff = cfg_x4 ? (BEAT_W'(sel_pbl) << 2) : BEAT_W'(sel_pbl);
    end

    bp_sizer #(
        .LEN_W (LEN_W),
        .BEAT_W(BEAT_W),
        .BND_LG(BND_LG),
        .IDX_W (IDX_W)
    ) u_sizer (
        .widx   (addr_q[IDX_W+1:2]),
        .rem    (rem_q),
        .max_len(max_q),
        .fixed  (fixed_q),
        .mixed  (mixed_q),
        .aligned(aligned_q),
        .first  (first_q),
        .beats  (nx_beats),
        .burst  (nx_burst)
    );

    always_comb begin
        take_start = (state_q == ST_IDLE) && start_valid;
        take_cmd   = (state_q == ST_ISSUE) && cmd_ready;
        last_cmd   = (rem_q == LEN_W'(nx_beats));
    end

    // Next state: START / EMPTY out of IDLE, NEXT / LAST out of ISSUE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take_start && total_words != '0) state_d = ST_ISSUE;
            ST_ISSUE: if (take_cmd && last_cmd)            state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            rem_q     <= '0;
            first_q   <= 1'b0;
            fixed_q   <= 1'b0;
            mixed_q   <= 1'b0;
            aligned_q <= 1'b0;
            max_q     <= BEAT_W'(1);
        end else if (take_start) begin
            addr_q    <= start_addr;
            rem_q     <= total_words;
            first_q   <= 1'b1;
            fixed_q   <= cfg_fixed;
            mixed_q   <= cfg_mixed;
            aligned_q <= cfg_aligned;
            max_q     <= sel_eff;
        end else if (take_cmd) begin
            addr_q  <= addr_q + (ADDR_W'(nx_beats) << 2);
            rem_q   <= rem_q - LEN_W'(nx_beats);
            first_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        start_ready = (state_q == ST_IDLE);
        cmd_valid   = (state_q == ST_ISSUE);
        cmd_addr    = addr_q;
        cmd_beats   = nx_beats;
        cmd_burst   = nx_burst;
    end

    AST_BEATS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_beats != '0 && cmd_beats <= max_q)); // R3

    AST_FIXED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && fixed_q) |-> (cmd_burst != HB_INCR)); // R4

    AST_CODE_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_burst != HB_INCR) |->
        ((cmd_burst == HB_SINGLE && cmd_beats == BEAT_W'(1)) ||
         (cmd_burst == HB_INCR4  && cmd_beats == BEAT_W'(4)) ||
         (cmd_burst == HB_INCR8  && cmd_beats == BEAT_W'(8)) ||
         (cmd_burst == HB_INCR16 && cmd_beats == BEAT_W'(16)))); // R4

    AST_FIXED_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && fixed_q && aligned_q) |->
        ((cmd_addr[5:2] & (cmd_beats[3:0] - 4'd1)) == 4'd0)); // R7

    AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ((IDX_W+1)'(cmd_addr[BND_LG+1:2]) + (IDX_W+1)'(cmd_beats)
                       <= (IDX_W+1)'(1 << BND_LG))); // R9

    AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
        (cmd_valid && $stable(cmd_addr) && $stable(cmd_beats) && $stable(cmd_burst))); // R10

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (LEN_W'(cmd_beats) <= rem_q)); // R2
endmodule

// File: tb/sim_dma_burst_planner.sv
module sim_dma_burst_planner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic        start_ready;
    logic [31:0] start_addr = '0;
    logic [15:0] total_words = '0;
    logic        dir_rx = 1'b0;
    logic        cfg_fixed = 1'b0, cfg_mixed = 1'b0, cfg_aligned = 1'b0;
    logic        cfg_x4 = 1'b0, cfg_sep_rx = 1'b0;
    logic [5:0]  cfg_pbl = 6'd1, cfg_rx_pbl = 6'd1;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_addr;
    logic [2:0]  cmd_burst;
    logic [7:0]  cmd_beats;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dma_burst_planner u0 (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_ready(start_ready),
        .start_addr(start_addr), .total_words(total_words), .dir_rx(dir_rx),
        .cfg_fixed(cfg_fixed), .cfg_mixed(cfg_mixed), .cfg_aligned(cfg_aligned),
        .cfg_x4(cfg_x4), .cfg_sep_rx(cfg_sep_rx),
        .cfg_pbl(cfg_pbl), .cfg_rx_pbl(cfg_rx_pbl),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_burst(cmd_burst), .cmd_beats(cmd_beats)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic begin_xfer(input logic [31:0] a, input logic [15:0] w, input bit rx,
                              input bit fx, input bit mx, input bit al, input bit x4,
                              input bit sep, input logic [5:0] p, input logic [5:0] rp);
        @(negedge clk);
        start_addr = a; total_words = w; dir_rx = rx;
        cfg_fixed = fx; cfg_mixed = mx; cfg_aligned = al; cfg_x4 = x4;
        cfg_sep_rx = sep; cfg_pbl = p; cfg_rx_pbl = rp;
        start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
    endtask

    task automatic expect_cmd(input logic [31:0] a, input logic [2:0] b,
                              input logic [7:0] n, input string req);
        check(cmd_valid === 1'b1, req, "cmd_valid", 32'(cmd_valid), 32'd1);
        check(cmd_addr === a, req, "cmd_addr", cmd_addr, a);
        check(cmd_burst === b, req, "cmd_burst", 32'(cmd_burst), 32'(b));
        check(cmd_beats === n, req, "cmd_beats", 32'(cmd_beats), 32'(n));
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    task automatic expect_idle(input string req);
        check(start_ready === 1'b1 && cmd_valid === 1'b0, req, "idle after transfer",
              {30'd0, start_ready, cmd_valid}, 32'h2);
    endtask

    task automatic t_reset;
        check(start_ready === 1'b1, "R1", "start_ready after reset", 32'(start_ready), 32'd1);
        check(cmd_valid === 1'b0, "R1", "cmd_valid after reset", 32'(cmd_valid), 32'd0);
    endtask

    task automatic t_fixed_split;
        logic [31:0] a0;
        begin_xfer(32'h1000, 16'd29, 0, 1, 0, 0, 0, 0, 6'd16, 6'd1);
        check(start_ready === 1'b0, "R1", "start_ready while busy", 32'(start_ready), 32'd0);
        a0 = cmd_addr;
        repeat (3) @(negedge clk);
        check(cmd_valid === 1'b1 && cmd_addr === a0 && cmd_beats === 8'd16, "R10",
              "held command", cmd_addr, a0);
        expect_cmd(32'h1000, 3'b111, 8'd16, "R4");
        expect_cmd(32'h1040, 3'b101, 8'd8,  "R4");
        expect_cmd(32'h1060, 3'b011, 8'd4,  "R2");
        expect_cmd(32'h1070, 3'b000, 8'd1,  "R2");
        expect_idle("R1");
    endtask

    task automatic t_plain_incr;
        begin_xfer(32'h2000, 16'd200, 0, 0, 0, 0, 1, 0, 6'd32, 6'd1);
        expect_cmd(32'h2000, 3'b001, 8'd128, "R11");
        expect_cmd(32'h2200, 3'b001, 8'd72,  "R5");
        expect_idle("R1");
        begin_xfer(32'h0500, 16'd1, 0, 0, 0, 0, 0, 0, 6'd8, 6'd1);
        expect_cmd(32'h0500, 3'b000, 8'd1, "R5");
        expect_idle("R1");
    endtask

    task automatic t_boundary;
        begin_xfer(32'h03F0, 16'd10, 0, 0, 0, 0, 1, 0, 6'd32, 6'd1);
        expect_cmd(32'h03F0, 3'b001, 8'd4, "R9");
        expect_cmd(32'h0400, 3'b001, 8'd6, "R9");
        expect_idle("R1");
    endtask

    task automatic t_mixed;
        begin_xfer(32'h4000, 16'd45, 0, 0, 1, 0, 0, 0, 6'd32, 6'd1);
        expect_cmd(32'h4000, 3'b001, 8'd32, "R6");
        expect_cmd(32'h4080, 3'b101, 8'd8,  "R6");
        expect_cmd(32'h40A0, 3'b011, 8'd4,  "R6");
        expect_cmd(32'h40B0, 3'b000, 8'd1,  "R6");
        expect_idle("R1");
    endtask

    task automatic t_aligned_fixed;
        begin_xfer(32'h5004, 16'd20, 0, 1, 0, 1, 0, 0, 6'd16, 6'd1);
        expect_cmd(32'h5004, 3'b000, 8'd1, "R7");
        expect_cmd(32'h5008, 3'b000, 8'd1, "R7");
        expect_cmd(32'h500C, 3'b000, 8'd1, "R7");
        expect_cmd(32'h5010, 3'b011, 8'd4, "R7");
        expect_cmd(32'h5020, 3'b101, 8'd8, "R7");
        expect_cmd(32'h5040, 3'b011, 8'd4, "R7");
        expect_cmd(32'h5050, 3'b000, 8'd1, "R7");
        expect_idle("R1");
    endtask

    task automatic t_aligned_plain;
        begin_xfer(32'h6008, 16'd20, 0, 0, 0, 1, 0, 0, 6'd8, 6'd1);
        expect_cmd(32'h6008, 3'b001, 8'd6, "R8");
        expect_cmd(32'h6020, 3'b001, 8'd8, "R8");
        expect_cmd(32'h6040, 3'b001, 8'd6, "R8");
        expect_idle("R1");
    endtask

    task automatic t_separate;
        begin_xfer(32'h7000, 16'd16, 1, 1, 0, 0, 0, 1, 6'd4, 6'd16);
        expect_cmd(32'h7000, 3'b111, 8'd16, "R12");
        expect_idle("R1");
        begin_xfer(32'h7000, 16'd16, 0, 1, 0, 0, 0, 1, 6'd4, 6'd16);
        for (int i = 0; i < 4; i++)
            expect_cmd(32'h7000 + 32'(i * 16), 3'b011, 8'd4, "R12");
        expect_idle("R1");
        begin_xfer(32'h7100, 16'd4, 1, 1, 0, 0, 0, 0, 6'd4, 6'd16);
        expect_cmd(32'h7100, 3'b011, 8'd4, "R12");
        expect_idle("R1");
    endtask

    task automatic t_x4;
        begin_xfer(32'h8000, 16'd8, 0, 1, 0, 0, 1, 0, 6'd2, 6'd1);
        expect_cmd(32'h8000, 3'b101, 8'd8, "R11");
        expect_idle("R1");
        begin_xfer(32'h8000, 16'd2, 0, 1, 0, 0, 0, 0, 6'd2, 6'd1);
        expect_cmd(32'h8000, 3'b000, 8'd1, "R3");
        expect_cmd(32'h8004, 3'b000, 8'd1, "R3");
        expect_idle("R1");
    endtask

    task automatic t_zero_len;
        begin_xfer(32'h9000, 16'd0, 0, 1, 0, 0, 0, 0, 6'd16, 6'd1);
        check(start_ready === 1'b1 && cmd_valid === 1'b0, "R1", "zero-length start",
              {30'd0, start_ready, cmd_valid}, 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed_split();
        t_plain_incr();
        t_boundary();
        t_mixed();
        t_aligned_fixed();
        t_aligned_plain();
        t_separate();
        t_x4();
        t_zero_len();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule